// File: doc/BRIEF.md
# Floating-Point Predicate Compare Unit

This unit compares two IEEE-754 operands of the same precision, either single (binary32) or double (binary64), under one of eleven predicates. Each predicate is either ordered, which is false when a NaN is involved, or unordered, which is true when a NaN is involved. The unit treats positive and negative zero as equal. It orders all other non-NaN values by sign and magnitude on their raw bit patterns.

The result goes to one of two places. In mask mode it becomes a register-wide mask of all ones or all zeros, which suits a branch-free select. In condition mode it becomes one bit of an eight-entry condition-code vector that later branch logic reads. A request is accepted on any cycle in which `in_valid` is high. Its result appears one clock later. Signalling-NaN exception flags are not produced.

Top module: `fpcmp_unit`

## Requirements
- R1: Predicate code 0 (never) is always false: in mask mode the mask becomes zero, and in condition mode the selected condition bit is cleared.
- R2: Code 1 (unordered) is true exactly when at least one operand is NaN. Code 8 (ordered) is true exactly when neither operand is NaN. A NaN has an all-ones exponent and a non-zero fraction.
- R3: Codes 2 (equal), 4 (less) and 6 (less-or-equal) are true only when both operands are non-NaN and the relation holds. +0 and -0 are equal, and negative values order by descending magnitude.
- R4: Codes 3, 5 and 7 are true when equal, less or less-or-equal holds, respectively, or when either operand is NaN.
- R5: Code 9 is true when the operands are unequal or either is NaN. Code 10 is true only when both are non-NaN and unequal.
- R6: With `is_double`=1 the operands are all 64 bits and a true mask is all 64 ones. With `is_double`=0 the operands are bits 31:0, bits 63:32 of the operands are ignored, and a true mask is 32'hFFFFFFFF in bits 31:0 with bits 63:32 zero.
- R7: With `use_cc`=1, only `cc_vec[cc_idx]` takes the predicate result. The other condition bits and the mask keep their values.
- R8: Codes 11 to 15 are always false.
- R9: Reset clears `mask`, `cc_vec` and `out_valid`. A request presented at a clock edge updates the outputs at that edge, and `out_valid` follows `in_valid` by one cycle. Without a request, `mask` and `cc_vec` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | First operand (left side of the relation) |
| op_b | input | 64 | Second operand |
| is_double | input | 1 | 1 = binary64, 0 = binary32 in bits 31:0 |
| pred | input | 4 | Predicate code |
| use_cc | input | 1 | 1 = write a condition bit, 0 = write the mask |
| cc_idx | input | 3 | Condition bit to write |
| mask | output | 64 | Mask result |
| cc_vec | output | 8 | Condition-code vector |
| out_valid | output | 1 | Result strobe, one cycle after the request |

## Verification
The result of every request is visible at the ports one cycle after the request, so an internal error appears at that same sample. Errors in NaN detection, in the zero-equality rule or in negative-magnitude ordering show up as a wrong mask bit pattern or a wrong condition bit. A condition-mode write to the wrong position shows up in the next `cc_vec` sample as a changed neighbour bit. It stays visible until that bit is written again. The bench computes the expected relation from real-number comparisons, independently of the bit-level ordering used in the design.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

   typedef enum logic [3:0] {
      PR_NEVER = 4'd0,
      PR_UNORD = 4'd1,
      PR_EQ    = 4'd2,
      PR_UEQ   = 4'd3,
      PR_LT    = 4'd4,
      PR_ULT   = 4'd5,
      PR_LE    = 4'd6,
      PR_ULE   = 4'd7,
      PR_ORD   = 4'd8,
      PR_UNE   = 4'd9,
      PR_NE    = 4'd10
   } pred_e;

   // relation of a to b
   typedef struct packed {
      logic unord;
      logic eq;
      logic lt;
   } rel_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W    = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] x,
   output logic         is_nan,
   output logic         is_zero,
   output logic         sign,
   output logic [W-2:0] mag
);
   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] frac;

   always_comb begin
      sign    = x[W-1];
      mag     = x[W-2:0];
      expo    = x[W-2:MAN_W];
      frac    = x[MAN_W-1:0];
      is_nan  = (&expo) && (|frac);
      is_zero = (mag == '0);
   end
endmodule

// File: rtl/fpcmp_relate.sv
module fpcmp_relate
   import fpcmp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W    = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output rel_t         rel
);
   logic         a_nan, b_nan, a_zero, b_zero, a_sgn, b_sgn;
   logic [W-2:0] a_mag, b_mag;
   logic         both_zero, mag_lt, mag_gt, raw_lt;

   fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
      .x(a), .is_nan(a_nan), .is_zero(a_zero), .sign(a_sgn), .mag(a_mag));
   fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
      .x(b), .is_nan(b_nan), .is_zero(b_zero), .sign(b_sgn), .mag(b_mag));

   always_comb begin
      both_zero = a_zero && b_zero;
      mag_lt    = a_mag < b_mag;
      mag_gt    = a_mag > b_mag;
      // sign-magnitude order: negatives reverse the magnitude relation
      unique case ({a_sgn, b_sgn})
         2'b10:   raw_lt = 1'b1;
         2'b01:   raw_lt = 1'b0;
         2'b00:   raw_lt = mag_lt;
         default: raw_lt = mag_gt;
      endcase
      rel.unord = a_nan || b_nan;
      rel.eq    = !rel.unord && (both_zero || (a == b));
      rel.lt    = !rel.unord && !both_zero && raw_lt;
   end
endmodule

// File: rtl/fpcmp_decide.sv
module fpcmp_decide
   import fpcmp_pkg::*;
(
   input  rel_t       rel,
   input  logic [3:0] code,
   output logic       hit
);
   always_comb begin
      case (pred_e'(code))
         PR_NEVER: hit = 1'b0;
         PR_UNORD: hit = rel.unord;
         PR_EQ:    hit = rel.eq;
         PR_UEQ:   hit = rel.eq || rel.unord;
         PR_LT:    hit = rel.lt;
         PR_ULT:   hit = rel.lt || rel.unord;
         PR_LE:    hit = rel.lt || rel.eq;
         PR_ULE:   hit = rel.lt || rel.eq || rel.unord;
         PR_ORD:   hit = !rel.unord;
         PR_UNE:   hit = !rel.eq;
         PR_NE:    hit = !rel.eq && !rel.unord;
         default:  hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
   import fpcmp_pkg::*;
#(
   parameter int SP_EXP_W = 8,
   parameter int SP_MAN_W = 23,
   parameter int DP_EXP_W = 11,
   parameter int DP_MAN_W = 52,
   parameter int CC_NUM   = 8,
   localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W,
   localparam int DP_W     = 1 + DP_EXP_W + DP_MAN_W,
   localparam int CC_IDX_W = (CC_NUM > 1) ? $clog2(CC_NUM) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [DP_W-1:0]     op_a,
   input  logic [DP_W-1:0]     op_b,
   input  logic                is_double,
   input  logic [3:0]          pred,
   input  logic                use_cc,
   input  logic [CC_IDX_W-1:0] cc_idx,
   output logic [DP_W-1:0]     mask,
   output logic [CC_NUM-1:0]   cc_vec,
   output logic                out_valid
);
   localparam logic [DP_W-1:0] SP_ONES = {{(DP_W-SP_W){1'b0}}, {SP_W{1'b1}}};
   localparam logic [DP_W-1:0] DP_ONES = '1;

   initial begin : elab_chk
      assert (SP_W < DP_W) else $fatal(1, "single width must be below double width");
      assert (SP_EXP_W < DP_EXP_W) else $fatal(1, "exponent widths inconsistent");
      assert (CC_NUM >= 1 && CC_NUM <= 64) else $fatal(1, "CC_NUM out of range");
   end

   rel_t rel_sp, rel_dp, rel_sel;
   logic hit;

   fpcmp_relate #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_rel_sp (
      .a(op_a[SP_W-1:0]), .b(op_b[SP_W-1:0]), .rel(rel_sp));
   fpcmp_relate #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_rel_dp (
      .a(op_a), .b(op_b), .rel(rel_dp));

   assign rel_sel = is_double ? rel_dp : rel_sp;

   fpcmp_decide u_decide (.rel(rel_sel), .code(pred), .hit(hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         mask      <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid && !use_cc)
            mask <= hit ? (is_double ? DP_ONES : SP_ONES) : '0;
      end
   end

   for (genvar i = 0; i < CC_NUM; i++) begin : g_cc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cc_vec[i] <= 1'b0;
         else if (in_valid && use_cc && (cc_idx == CC_IDX_W'(i)))
            cc_vec[i] <= hit;
      end
   end
endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker #(
   parameter int SP_W     = 32,
   parameter int DP_W     = 64,
   parameter int CC_NUM   = 8,
   parameter int CC_IDX_W = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                is_double,
   input logic [3:0]          pred,
   input logic                use_cc,
   input logic [CC_IDX_W-1:0] cc_idx,
   input logic [DP_W-1:0]     mask,
   input logic [CC_NUM-1:0]   cc_vec,
   input logic                out_valid
);
   localparam logic [DP_W-1:0] SP_ONES = {{(DP_W-SP_W){1'b0}}, {SP_W{1'b1}}};

   p_never_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !use_cc && pred == 4'd0 |=> mask == '0);
   p_never_cc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && use_cc && pred == 4'd0 |=> cc_vec[$past(cc_idx)] == 1'b0);
   p_sp_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !use_cc && !is_double |=> mask[DP_W-1:SP_W] == '0);
   p_mask_form_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (mask == '0) || (mask == SP_ONES) || (&mask));
   p_cc_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && use_cc |=> $stable(mask));
   p_cc_others_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && use_cc |=>
         ((cc_vec ^ $past(cc_vec)) & ~(CC_NUM'(1) << $past(cc_idx))) == '0);
   p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !use_cc && pred > 4'd10 |=> mask == '0);
   p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(mask) && $stable(cc_vec));
endmodule

bind fpcmp_unit fpcmp_checker #(
   .SP_W(SP_W), .DP_W(DP_W), .CC_NUM(CC_NUM), .CC_IDX_W(CC_IDX_W)
) u_fpcmp_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_double(is_double),
   .pred(pred), .use_cc(use_cc), .cc_idx(cc_idx), .mask(mask),
   .cc_vec(cc_vec), .out_valid(out_valid)
);

// File: tb/tb_fpcmp_unit.sv
module tb_fpcmp_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] op_a = '0, op_b = '0;
   logic        is_double = 1'b0;
   logic [3:0]  pred = '0;
   logic        use_cc = 1'b0;
   logic [2:0]  cc_idx = '0;
   logic [63:0] mask;
   logic [7:0]  cc_vec;
   logic        out_valid;

   int checks = 0;
   int errors = 0;
   logic [63:0] exp_mask = '0;
   logic [7:0]  exp_cc = '0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   fpcmp_unit dut (.*);

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic string tag_of(input logic [3:0] p);
      case (p)
         4'd0:             return "R1";
         4'd1, 4'd8:       return "R2";
         4'd2, 4'd4, 4'd6: return "R3";
         4'd3, 4'd5, 4'd7: return "R4";
         4'd9, 4'd10:      return "R5";
         default:          return "R8";
      endcase
   endfunction

   function automatic bit is_nan_v(input logic [63:0] v, input bit dbl);
      if (dbl) return (v[62:52] == 11'h7ff) && (v[51:0] != 0);
      return (v[30:23] == 8'hff) && (v[22:0] != 0);
   endfunction

   function automatic real to_real(input logic [63:0] v, input bit dbl);
      logic [31:0] s;
      real r;
      if (dbl) return $bitstoreal(v);
      s = v[31:0];
      if (s[30:23] == 8'h00) begin
         r = real'(s[22:0]) / (2.0 ** 149);
         return s[31] ? -r : r;
      end
      if (s[30:23] == 8'hff)
         return $bitstoreal({s[31], 11'h7ff, 52'd0});
      return $bitstoreal({s[31], 11'(s[30:23]) + 11'd896, s[22:0], 29'd0});
   endfunction

   function automatic bit model(input logic [63:0] a, input logic [63:0] b,
                                input bit dbl, input logic [3:0] p);
      bit u, e, l;
      real ra, rb;
      u = is_nan_v(a, dbl) || is_nan_v(b, dbl);
      e = 1'b0; l = 1'b0;
      if (!u) begin
         ra = to_real(a, dbl);
         rb = to_real(b, dbl);
         e = (ra == rb);
         l = (ra < rb);
      end
      case (p)
         4'd1:  return u;
         4'd2:  return e;
         4'd3:  return e | u;
         4'd4:  return l;
         4'd5:  return l | u;
         4'd6:  return l | e;
         4'd7:  return l | e | u;
         4'd8:  return !u;
         4'd9:  return !e;
         4'd10: return !e && !u;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check64(input string tag, input string what,
                          input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic run(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                      input logic [3:0] p, input bit cc, input logic [2:0] idx);
      bit h;
      h = model(a, b, dbl, p);
      @(negedge clk);
      op_a = a; op_b = b; is_double = dbl; pred = p; use_cc = cc; cc_idx = idx;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (cc) exp_cc[idx] = h;
      else exp_mask = h ? (dbl ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF) : 64'd0;
      check64("R9", "out_valid", {63'd0, out_valid}, 64'd1);
      if (cc) begin
         check64(tag_of(p), "cc_vec (R7)", {56'd0, cc_vec}, {56'd0, exp_cc});
         check64("R7", "mask held", mask, exp_mask);
      end else begin
         check64(tag_of(p), dbl ? "mask dp (R6)" : "mask sp (R6)", mask, exp_mask);
         check64("R7", "cc held", {56'd0, cc_vec}, {56'd0, exp_cc});
      end
   endtask

   function automatic logic [63:0] pick(input bit dbl);
      int unsigned k;
      k = $urandom % 12;
      if (dbl) begin
         case (k)
            0: return 64'h0;
            1: return 64'h8000_0000_0000_0000;
            2: return 64'h7FF0_0000_0000_0000;
            3: return 64'hFFF0_0000_0000_0000;
            4: return 64'h7FF8_0000_0000_0000;
            5: return 64'h3FF0_0000_0000_0000;
            6: return 64'hBFF0_0000_0000_0000;
            7: return {$urandom, $urandom} & 64'h800F_FFFF_FFFF_FFFF;
            default: return {$urandom, $urandom};
         endcase
      end else begin
         case (k)
            0: return {$urandom, 32'h0};
            1: return {$urandom, 32'h8000_0000};
            2: return {$urandom, 32'h7F80_0000};
            3: return {$urandom, 32'hFF80_0000};
            4: return {$urandom, 32'h7F80_0001};
            5: return {$urandom, 32'h3F80_0000};
            6: return {$urandom, 32'hBF80_0000};
            7: return {$urandom, $urandom & 32'h807F_FFFF};
            default: return {$urandom, $urandom};
         endcase
      end
   endfunction

   initial begin : stim
      int unsigned seed_dummy;
      logic [63:0] a, b;
      bit dbl;
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R9: reset state
      check64("R9", "mask at reset", mask, 64'd0);
      check64("R9", "cc at reset", {56'd0, cc_vec}, 64'd0);
      check64("R9", "out_valid at reset", {63'd0, out_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check64("R9", "out_valid idle", {63'd0, out_valid}, 64'd0);

      // R3: signed zeros equal, negatives order by magnitude
      run(64'h0, 64'h8000_0000_0000_0000, 1'b1, 4'd2, 1'b0, 3'd0);
      run(64'h0, 64'h8000_0000_0000_0000, 1'b1, 4'd4, 1'b0, 3'd0);
      run(64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, 1'b1, 4'd4, 1'b0, 3'd0);
      run({32'hDEAD_BEEF, 32'hC000_0000}, {32'h1234_5678, 32'hBF80_0000}, 1'b0, 4'd6, 1'b0, 3'd0);
      // R2/R4/R5 with NaN
      run(64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b1, 4'd1, 1'b0, 3'd0);
      run(64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b1, 4'd8, 1'b0, 3'd0);
      run({32'h0, 32'h7F80_0001}, {32'h0, 32'h7F80_0001}, 1'b0, 4'd3, 1'b0, 3'd0);
      run({32'h0, 32'h7FC0_0000}, {32'h0, 32'h0}, 1'b0, 4'd10, 1'b0, 3'd0);
      run({32'h0, 32'h7FC0_0000}, {32'h0, 32'h0}, 1'b0, 4'd9, 1'b0, 3'd0);
      // R6: upper bits ignored in single mode
      run({32'hFFFF_FFFF, 32'h3F80_0000}, {32'h0, 32'h3F80_0000}, 1'b0, 4'd2, 1'b0, 3'd0);
      // R1 in both modes
      run(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b1, 4'd0, 1'b0, 3'd0);
      run(64'h0, 64'h0, 1'b1, 4'd2, 1'b1, 3'd5);
      run(64'h0, 64'h0, 1'b1, 4'd0, 1'b1, 3'd5);
      // R8: unused codes
      run(64'h0, 64'h0, 1'b1, 4'd12, 1'b0, 3'd0);
      run(64'h0, 64'h0, 1'b1, 4'd15, 1'b1, 3'd2);
      // R7: fill condition bits
      for (int i = 0; i < 8; i++)
         run(64'h0, 64'h3FF0_0000_0000_0000, 1'b1, 4'd4, 1'b1, 3'(i));

      for (int n = 0; n < 600; n++) begin
         dbl = ($urandom % 2) == 1;
         a = pick(dbl);
         b = (($urandom % 5) == 0) ? a : pick(dbl);
         run(a, b, dbl, 4'($urandom % 16), (($urandom % 3) == 0), 3'($urandom % 8));
      end

      // R9: holding without a request
      repeat (3) @(negedge clk);
      check64("R9", "mask hold idle", mask, exp_mask);
      check64("R9", "cc hold idle", {56'd0, cc_vec}, {56'd0, exp_cc});
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule